// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank-State Tracker

This block watches the command pins of a double-data-rate SDRAM from the device side. On every rising clock edge it samples the inverted chip select, row strobe, column strobe and write enable, together with the clock enable, the two bank-address bits and address bit 10. It turns each sampled command into a one-hot pulse with a legality flag. It keeps an open or closed flag for each of the four banks, and it tracks whether the device is running or in one of its three low-power states.

Verification and protocol-checking environments use it to catch controller errors. It flags a column access to a closed bank, a row open to a bank that is already open, a burst stop with no plain read running, and a refresh that would exceed the posting limit. A per-bank counter also flags a column access that comes too soon after its row was opened. The clock-enable history decides how the refresh encoding is read and whether the device enters or leaves power-down.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Inputs are sampled only on the rising edge, and results are registered and visible after that same edge. The command code is {csN,rasN,casN,weN}: 0111 no-op, 0011 row open, 0101 read, 0100 write, 0110 burst stop, 0010 precharge, 0001 refresh, 0000 mode set. When csN is high the command is a no-op, identical to code 0111. The cmdPulse bits are 0 no-op, 1 row open, 2 read, 3 write, 4 burst stop, 5 single-bank precharge, 6 all-bank precharge, 7 auto refresh, 8 self-refresh entry and 9 mode set. At most one bit is high. cmdLegal is high only together with a pulse, and no-op is always legal.
- R2: A row open to a closed bank is legal and sets that bank's bankActive bit. A row open to an open bank is illegal and changes nothing.
- R3: A read or write to an open bank is legal. A read or write to a closed bank is illegal and changes nothing. If a10 is high on a legal read or write, that bank closes after the access; the choice applies to that one command only.
- R4: A precharge with a10 low closes only bank ba and pulses bit 5. With a10 high it closes all banks regardless of ba and pulses bit 6. Both are always legal.
- R5: A burst stop is legal only while a read issued without auto-precharge is the latest column command. A write, a read with auto-precharge, any precharge or a burst stop ends that window. An illegal burst stop changes nothing.
- R6: With clock enable high on two edges, the refresh code is an auto refresh. It is legal only when all banks are closed and fewer than REF_POST_MAX (8) refreshes are posted, and each legal one posts a refresh. Every RETIRE_CYCLES edges, one posted refresh retires if any is posted. A mode set is legal only when all banks are closed.
- R7: pwrState encodes 0 running, 1 idle power-down, 2 active power-down and 3 self refresh. If cke is sampled low while running and the command is not refresh, the block enters state 1 when all banks are closed and state 2 otherwise. No pulse is produced on that edge.
- R8: If cke is sampled low while running and the command is refresh, bit 8 pulses. This is legal and enters state 3 when all banks are closed. It is illegal and enters state 2 when any bank is open.
- R9: In a low-power state, cke low holds the state, produces no pulse and leaves the bank state unchanged. The first edge with cke high returns pwrState to 0 and ignores the command on that edge.
- R10: A legal read or write sampled fewer than ACT_TO_RW edges after the row open of its bank raises timingViol for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge samples |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| cmdPulse | output | 10 | One-hot decoded command of the last edge |
| cmdLegal | output | 1 | Decoded command was legal |
| timingViol | output | 1 | Column access too soon after row open |
| bankActive | output | 4 | Open flag per bank |
| pwrState | output | 2 | Running or low-power state |

## Verification
A wrong bank flag shows up on bankActive one cycle after the offending command. It then corrupts the legality of the next row open or column access to that bank. A stale burst-stop window or refresh count stays hidden until the next burst stop or refresh, so the stimulus issues these right after the commands that change them. A power-state error shows on pwrState at once, and it also shows as pulses that appear, or go missing, on the following edges.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int BANK_BITS = 2;
  localparam int BANKS     = 1 << BANK_BITS;
  localparam int CMD_NUM   = 10;

  localparam int IDX_NOP   = 0;
  localparam int IDX_ACT   = 1;
  localparam int IDX_RD    = 2;
  localparam int IDX_WR    = 3;
  localparam int IDX_BST   = 4;
  localparam int IDX_PRE   = 5;
  localparam int IDX_PREA  = 6;
  localparam int IDX_AREF  = 7;
  localparam int IDX_SREF  = 8;
  localparam int IDX_MRS   = 9;

  typedef enum logic [1:0] {
    PWR_RUN    = 2'd0,
    PWR_PRE_PD = 2'd1,
    PWR_ACT_PD = 2'd2,
    PWR_SELF   = 2'd3
  } pwr_e;

  // strobes from control to the bank datapath
  typedef struct packed {
    logic [BANKS-1:0] openMask;
    logic [BANKS-1:0] closeMask;
    logic             refPost;
    logic             bstSet;
    logic             bstClr;
  } strobe_t;
endpackage

// File: rtl/bank_dp.sv
module bank_dp
  import sdcmd_pkg::*;
#(
  parameter int ACT_TO_RW     = 3,
  parameter int REF_POST_MAX  = 8,
  parameter int RETIRE_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic [BANKS-1:0] bankActive,
  output logic [BANKS-1:0] bankReady,
  output logic             refFull,
  output logic             bstOk
);
  localparam int TW = $clog2(ACT_TO_RW + 1);
  localparam int PW = $clog2(REF_POST_MAX + 1);
  localparam int KW = $clog2(RETIRE_CYCLES);

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    logic [TW-1:0] sinceAct;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankActive[i] <= 1'b0;
        sinceAct      <= TW'(ACT_TO_RW);
      end else begin
        if (strb.openMask[i])       bankActive[i] <= 1'b1;
        else if (strb.closeMask[i]) bankActive[i] <= 1'b0;
        if (strb.openMask[i])                    sinceAct <= TW'(1);
        else if (sinceAct < TW'(ACT_TO_RW))      sinceAct <= sinceAct + TW'(1);
      end
    end
    assign bankReady[i] = (sinceAct >= TW'(ACT_TO_RW));
  end

  logic [PW-1:0] postCnt;
  logic [KW-1:0] tickCnt;
  logic          tick;
  logic          retire;

  assign tick    = (tickCnt == KW'(RETIRE_CYCLES - 1));
  assign retire  = tick && (postCnt != '0);
  assign refFull = (postCnt == PW'(REF_POST_MAX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      postCnt <= '0;
      bstOk   <= 1'b0;
    end else begin
      tickCnt <= tick ? '0 : tickCnt + KW'(1);
      postCnt <= postCnt + PW'(strb.refPost) - PW'(retire);
      if (strb.bstSet)      bstOk <= 1'b1;
      else if (strb.bstClr) bstOk <= 1'b0;
    end
  end

  AST_REF_CAP: assert property (@(posedge clk) disable iff (!rstN)
    postCnt <= PW'(REF_POST_MAX)); // R6
  AST_OPEN_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strb.openMask != '0 |=> (bankActive & $past(strb.openMask)) == $past(strb.openMask)); // R2
  AST_OPEN_CLOSE_APART: assert property (@(posedge clk) disable iff (!rstN)
    (strb.openMask & strb.closeMask) == '0); // R3
endmodule

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import sdcmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 cke,
  input  logic [BANK_BITS-1:0] ba,
  input  logic                 a10,
  input  logic [BANKS-1:0]     bankActive,
  input  logic [BANKS-1:0]     bankReady,
  input  logic                 refFull,
  input  logic                 bstOk,
  output strobe_t              strb,
  output logic [CMD_NUM-1:0]   cmdPulse,
  output logic                 cmdLegal,
  output logic                 timingViol,
  output pwr_e                 pwrState
);
  logic [CMD_NUM-1:0] nextPulse;
  logic               nextLegal;
  logic               nextViol;
  pwr_e               nextPwr;
  logic [2:0]         code;
  logic [BANKS-1:0]   bankSel;
  logic               allIdle;
  logic               bankOn;

  assign code    = {rasN, casN, weN};
  assign bankSel = BANKS'(1) << ba;
  assign allIdle = (bankActive == '0);
  assign bankOn  = bankActive[ba];

  always_comb begin
    nextPulse = '0;
    nextLegal = 1'b0;
    nextViol  = 1'b0;
    nextPwr   = pwrState;
    strb      = '0;
    if (pwrState != PWR_RUN) begin
      if (cke) nextPwr = PWR_RUN;
    end else if (!cke) begin
      if (!csN && code == 3'b001) begin
        nextPulse[IDX_SREF] = 1'b1;
        nextLegal           = allIdle;
        nextPwr             = allIdle ? PWR_SELF : PWR_ACT_PD;
      end else begin
        nextPwr = allIdle ? PWR_PRE_PD : PWR_ACT_PD;
      end
    end else if (csN) begin
      nextPulse[IDX_NOP] = 1'b1;
      nextLegal          = 1'b1;
    end else begin
      unique case (code)
        3'b111: begin
          nextPulse[IDX_NOP] = 1'b1;
          nextLegal          = 1'b1;
        end
        3'b011: begin
          nextPulse[IDX_ACT] = 1'b1;
          nextLegal          = !bankOn;
          if (!bankOn) strb.openMask = bankSel;
        end
        3'b101, 3'b100: begin
          nextPulse[weN ? IDX_RD : IDX_WR] = 1'b1;
          nextLegal = bankOn;
          if (bankOn) begin
            nextViol = !bankReady[ba];
            if (a10) strb.closeMask = bankSel;
            if (weN && !a10) strb.bstSet = 1'b1;
            else             strb.bstClr = 1'b1;
          end
        end
        3'b110: begin
          nextPulse[IDX_BST] = 1'b1;
          nextLegal          = bstOk;
          strb.bstClr        = bstOk;
        end
        3'b010: begin
          nextPulse[a10 ? IDX_PREA : IDX_PRE] = 1'b1;
          nextLegal      = 1'b1;
          strb.closeMask = a10 ? '1 : bankSel;
          strb.bstClr    = 1'b1;
        end
        3'b001: begin
          nextPulse[IDX_AREF] = 1'b1;
          nextLegal           = allIdle && !refFull;
          strb.refPost        = allIdle && !refFull;
        end
        default: begin
          nextPulse[IDX_MRS] = 1'b1;
          nextLegal          = allIdle;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdPulse   <= '0;
      cmdLegal   <= 1'b0;
      timingViol <= 1'b0;
      pwrState   <= PWR_RUN;
    end else begin
      cmdPulse   <= nextPulse;
      cmdLegal   <= nextLegal;
      timingViol <= nextViol;
      pwrState   <= nextPwr;
    end
  end

  AST_ONEHOT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdPulse)); // R1
  AST_LEGAL_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdLegal |-> cmdPulse != '0); // R1
  AST_BST_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPulse[IDX_BST] && cmdLegal) |-> $past(bstOk)); // R5
  AST_QUIET_LOWPWR: assert property (@(posedge clk) disable iff (!rstN)
    $past(pwrState) != PWR_RUN |-> cmdPulse == '0); // R9
  AST_PD_KIND: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrState) == PWR_RUN && pwrState == PWR_PRE_PD) |-> $past(bankActive) == '0); // R7
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int ACT_TO_RW     = 3,
  parameter int REF_POST_MAX  = 8,
  parameter int RETIRE_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 cke,
  input  logic [BANK_BITS-1:0] ba,
  input  logic                 a10,
  output logic [CMD_NUM-1:0]   cmdPulse,
  output logic                 cmdLegal,
  output logic                 timingViol,
  output logic [BANKS-1:0]     bankActive,
  output logic [1:0]           pwrState
);
  strobe_t          strb;
  logic [BANKS-1:0] bankReady;
  logic             refFull;
  logic             bstOk;
  pwr_e             pwrCur;

  assign pwrState = pwrCur;

  cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .ba(ba), .a10(a10), .bankActive(bankActive), .bankReady(bankReady),
    .refFull(refFull), .bstOk(bstOk), .strb(strb), .cmdPulse(cmdPulse),
    .cmdLegal(cmdLegal), .timingViol(timingViol), .pwrState(pwrCur)
  );

  bank_dp #(
    .ACT_TO_RW(ACT_TO_RW), .REF_POST_MAX(REF_POST_MAX), .RETIRE_CYCLES(RETIRE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bankActive(bankActive),
    .bankReady(bankReady), .refFull(refFull), .bstOk(bstOk)
  );
endmodule

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
  localparam int ACT_TO_RW = 3;
  localparam int REF_MAX   = 8;
  localparam int RETIRE    = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [9:0] cmdPulse;
  logic cmdLegal, timingViol;
  logic [3:0] bankActive;
  logic [1:0] pwrState;

  always #10 clk = ~clk;

  sdram_cmd_tracker #(.ACT_TO_RW(ACT_TO_RW), .REF_POST_MAX(REF_MAX), .RETIRE_CYCLES(RETIRE)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .cke(cke),
    .ba(ba), .a10(a10), .cmdPulse(cmdPulse), .cmdLegal(cmdLegal), .timingViol(timingViol),
    .bankActive(bankActive), .pwrState(pwrState)
  );

  int checks = 0;
  int failures = 0;
  int mPwr = 0, mPosted = 0, mEdge = 0;
  bit mBst = 0;
  bit mAct [4];
  int mActEdge [4];
  logic [9:0] ePulse;
  logic eLegal, eViol;
  string tag;

  function automatic logic [3:0] actVec();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = mAct[i];
    return v;
  endfunction

  // behavioural reference, one sampled edge
  task automatic modelStep();
    bit allIdle = (actVec() == 4'd0);
    bit tick = (mEdge % RETIRE) == RETIRE - 1;
    bit doPost = 0;
    int b = int'(ba);
    ePulse = '0; eLegal = 0; eViol = 0; tag = "R1";
    if (mPwr != 0) begin
      tag = "R9";
      if (cke) mPwr = 0;
    end else if (!cke) begin
      if (!csN && {rasN, casN, weN} == 3'b001) begin
        tag = "R8"; ePulse[8] = 1; eLegal = allIdle; mPwr = allIdle ? 3 : 2;
      end else begin
        tag = "R7"; mPwr = allIdle ? 1 : 2;
      end
    end else if (csN || {rasN, casN, weN} == 3'b111) begin
      ePulse[0] = 1; eLegal = 1;
    end else begin
      case ({rasN, casN, weN})
        3'b011: begin
          tag = "R2"; ePulse[1] = 1; eLegal = !mAct[b];
          if (eLegal) begin mAct[b] = 1; mActEdge[b] = mEdge; end
        end
        3'b101, 3'b100: begin
          tag = "R3"; ePulse[weN ? 2 : 3] = 1; eLegal = mAct[b];
          if (eLegal) begin
            if (mEdge - mActEdge[b] < ACT_TO_RW) begin eViol = 1; tag = "R10"; end
            if (a10) mAct[b] = 0;
            mBst = weN && !a10;
          end
        end
        3'b110: begin tag = "R5"; ePulse[4] = 1; eLegal = mBst; mBst = 0; end
        3'b010: begin
          tag = "R4"; eLegal = 1; mBst = 0;
          if (a10) begin ePulse[6] = 1; for (int i = 0; i < 4; i++) mAct[i] = 0; end
          else begin ePulse[5] = 1; mAct[b] = 0; end
        end
        3'b001: begin
          tag = "R6"; ePulse[7] = 1; eLegal = allIdle && mPosted < REF_MAX; doPost = eLegal;
        end
        default: begin tag = "R6"; ePulse[9] = 1; eLegal = allIdle; end
      endcase
    end
    if (tick && mPosted > 0) mPosted--;
    if (doPost) mPosted++;
    mEdge++;
  endtask

  task automatic compare(string t);
    checks++;
    if (cmdPulse !== ePulse || cmdLegal !== eLegal || timingViol !== eViol ||
        bankActive !== actVec() || pwrState !== 2'(mPwr)) begin
      failures++;
      $display("FAIL %s edge=%0d got pulse=%b legal=%b viol=%b banks=%b pwr=%0d exp pulse=%b legal=%b viol=%b banks=%b pwr=%0d",
               t, mEdge, cmdPulse, cmdLegal, timingViol, bankActive, pwrState,
               ePulse, eLegal, eViol, actVec(), mPwr);
    end
  endtask

  // apply at negedge, model at posedge, compare at next negedge
  task automatic cyc(logic [3:0] cmd, logic k, logic [1:0] b, logic a);
    {csN, rasN, casN, weN} = cmd; cke = k; ba = b; a10 = a;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         BST = 4'b0110, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000,
                         DES = 4'b1000;

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mAct[i] = 0; mActEdge[i] = -1000; end
    repeat (3) @(negedge clk);
    ePulse = '0; eLegal = 0; eViol = 0;
    compare("R1 reset");
    rstN = 1'b1;
    // R1: no-op and deselect
    cyc(NOP, 1, 0, 0); cyc(DES, 1, 3, 1);
    // R2 R10 R3 R5
    cyc(ACT, 1, 0, 0); cyc(RD, 1, 0, 0); cyc(ACT, 1, 0, 0); cyc(RD, 1, 1, 0);
    cyc(BST, 1, 0, 0); cyc(BST, 1, 0, 0);
    cyc(WR, 1, 0, 0); cyc(BST, 1, 0, 0); cyc(RD, 1, 0, 1); cyc(BST, 1, 0, 0);
    cyc(WR, 1, 0, 0);
    // R4
    cyc(ACT, 1, 1, 0); cyc(ACT, 1, 2, 0); repeat (3) cyc(NOP, 1, 0, 0);
    cyc(RD, 1, 2, 0); cyc(PRE, 1, 1, 0); cyc(BST, 1, 2, 0); cyc(PRE, 1, 3, 1);
    // R6 mode set and refresh
    cyc(MRS, 1, 0, 0); cyc(ACT, 1, 3, 0); cyc(MRS, 1, 0, 0); cyc(REF, 1, 0, 0);
    cyc(PRE, 1, 0, 1);
    repeat (10) cyc(REF, 1, 0, 0);
    // R7 R9 R8
    cyc(NOP, 0, 0, 0); cyc(ACT, 0, 0, 0); cyc(ACT, 0, 1, 0); cyc(ACT, 1, 0, 0);
    cyc(ACT, 1, 0, 0); cyc(DES, 0, 0, 0); cyc(NOP, 1, 0, 0);
    cyc(REF, 0, 0, 0); cyc(NOP, 1, 0, 0); cyc(PRE, 1, 0, 1);
    cyc(REF, 0, 0, 0); cyc(REF, 0, 0, 0); cyc(NOP, 1, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] c;
      c = {($urandom_range(0, 7) == 0), 3'($urandom_range(0, 7))};
      cyc(c, $urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule